// File: doc/BRIEF.md
# Ultra DMA Write-Burst Receiver

This block is the device end of an Ultra DMA burst in which the host writes to the device. An internal transfer request makes the block raise its DMA request. Once the host acknowledges, the block raises its ready line. From then on it captures one 16-bit word on every host strobe transition, rising or falling, and presents each word with a one-cycle valid pulse. The strobe input must already be synchronized to the block clock.

The device can hold the host off for a while (pause) or close the burst (termination). In both cases it drops ready and keeps accepting the few words still in flight on the cable. During termination it waits a programmable minimum time before dropping the DMA request. It then ignores the host's closing strobe transition and takes the host's CRC word from the data bus when the acknowledge falls. A mismatch against its own running CRC sets a sticky error flag, which the next command start clears. The host can also end the burst itself with STOP.

The controller has six states. IDLE moves to REQUEST on a transfer request. REQUEST moves to XFER when the acknowledge is seen. XFER moves to PAUSE on a pause request. XFER moves to DRAIN on an accepted end request. XFER moves to CLOSE when STOP arrives. PAUSE moves back to XFER when the pause request is released. DRAIN moves to CLOSE when the hold time expires. CLOSE moves to IDLE when the acknowledge falls.

Top module: `udma_out_rx`

## Requirements
- R1: After reset, dma_req, dev_ready, word_valid and crc_err are all low.
- R2: A transfer request in IDLE raises dma_req on the next cycle. dev_ready rises on the cycle after dma_ack is sampled high, and the running CRC is reseeded at that point.
- R3: While dev_ready is high, each cycle in which host_strobe differs from its value in the previous cycle captures host_data. That word appears on word_data with word_valid high for exactly one cycle, on the next cycle.
- R4: An end request is not honoured until at least one word of the current burst has been captured. While the request waits, dev_ready stays high.
- R5: Once an end request is accepted, dev_ready goes low on the next cycle. dma_req then stays high for exactly T_RP further cycles (T_RP = 8 by default) and stays low until the burst has closed.
- R6: After an accepted end request, at most one further word is accepted if the request was taken within T_SR cycles (T_SR = 4 by default) of the last strobe transition. Otherwise at most two are accepted. Any further transitions are discarded.
- R7: A pause request in XFER drops dev_ready while dma_req stays high. Up to PAUSE_STRAYS further words (3 by default) are still accepted, and releasing the request raises dev_ready again.
- R8: Strobe transitions after dma_req has fallen, including the host's closing transition, produce no word.
- R9: When dma_ack falls in CLOSE, host_data is compared with the running CRC. That CRC is CRC-16 with polynomial 0x1021, seed 0x4ABA, processed MSB first, over every accepted word of the burst. A mismatch sets crc_err.
- R10: crc_err stays set until cmd_start is pulsed. A mismatch in a later burst keeps it set.
- R11: If host_stop is high in XFER, dev_ready and dma_req both drop on the next cycle, and the burst closes as in R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_req | input | 1 | Internal request to open a write burst |
| end_req | input | 1 | Internal request to terminate the burst |
| pause_req | input | 1 | Internal request to hold the host off |
| cmd_start | input | 1 | Start of a new command; clears crc_err |
| host_strobe | input | 1 | Synchronized host data strobe |
| host_stop | input | 1 | Host STOP line |
| dma_ack | input | 1 | Host DMA acknowledge, active high |
| host_data | input | 16 | Host data bus |
| dma_req | output | 1 | Device DMA request |
| dev_ready | output | 1 | Device ready to receive |
| word_data | output | 16 | Last captured word |
| word_valid | output | 1 | One-cycle pulse per captured word |
| crc_err | output | 1 | Sticky CRC mismatch flag |

## Verification
The end request and a strobe transition can land in the same cycle. When they do, the word is taken as a normal burst word and the stray allowance is set to the short form. The bench provokes this pair by raising the end request within a couple of cycles of the last word (short allowance) or well after it (long allowance). It then sends more stray transitions than either allowance, and compares the captured words and the closing CRC against lists built in the bench. A second coincidence occurs in the last DRAIN cycle: a stray word can be taken on the same edge that drops dma_req. It is judged by the exact hold-time count and the final word count.

// File: rtl/udma_rx_pkg.sv
`timescale 1ns/1ps
package udma_rx_pkg;

    localparam int UDMA_WORD_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQUEST,
        ST_XFER,
        ST_PAUSE,
        ST_DRAIN,
        ST_CLOSE
    } udma_state_t;

    function automatic logic [UDMA_WORD_W-1:0] crc16_step(
        input logic [UDMA_WORD_W-1:0] crc_in,
        input logic [UDMA_WORD_W-1:0] word,
        input logic [UDMA_WORD_W-1:0] poly
    );
        logic [UDMA_WORD_W-1:0] acc;
        logic                   fb;
        acc = crc_in;
        for (int i = UDMA_WORD_W - 1; i >= 0; i--) begin
            fb  = acc[UDMA_WORD_W-1] ^ word[i];
            acc = {acc[UDMA_WORD_W-2:0], 1'b0} ^ (fb ? poly : '0);
        end
        return acc;
    endfunction

endpackage

// File: rtl/udma_strobe_edge.sv
`timescale 1ns/1ps
module udma_strobe_edge #(
    parameter int GAP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    output logic             edge_o,
    output logic [GAP_W-1:0] gap_o
);
    logic strobe_q;

    assign edge_o = strobe ^ strobe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_q <= 1'b1;
            gap_o    <= '1;
        end else begin
            strobe_q <= strobe;
            if (edge_o)
                gap_o <= '0;
            else if (gap_o != '1)
                gap_o <= gap_o + 1'b1;
        end
    end
endmodule

// File: rtl/udma_hold_timer.sv
`timescale 1ns/1ps
module udma_hold_timer #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic done
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt;

    assign done = (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart)
            cnt <= '0;
        else if (!done)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/udma_crc_acc.sv
`timescale 1ns/1ps
module udma_crc_acc
    import udma_rx_pkg::*;
#(
    parameter logic [UDMA_WORD_W-1:0] POLY = 16'h1021,
    parameter logic [UDMA_WORD_W-1:0] SEED = 16'h4ABA
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reseed,
    input  logic                   step,
    input  logic [UDMA_WORD_W-1:0] word,
    output logic [UDMA_WORD_W-1:0] crc
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            crc <= SEED;
        else if (reseed)
            crc <= SEED;
        else if (step)
            crc <= crc16_step(crc, word, POLY);
    end
endmodule

// File: rtl/udma_out_rx.sv
`timescale 1ns/1ps
module udma_out_rx
    import udma_rx_pkg::*;
#(
    parameter int T_SR         = 4,
    parameter int T_RP         = 8,
    parameter int PAUSE_STRAYS = 3,
    parameter logic [UDMA_WORD_W-1:0] CRC_POLY = 16'h1021,
    parameter logic [UDMA_WORD_W-1:0] CRC_SEED = 16'h4ABA
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   xfer_req,
    input  logic                   end_req,
    input  logic                   pause_req,
    input  logic                   cmd_start,
    input  logic                   host_strobe,
    input  logic                   host_stop,
    input  logic                   dma_ack,
    input  logic [UDMA_WORD_W-1:0] host_data,
    output logic                   dma_req,
    output logic                   dev_ready,
    output logic [UDMA_WORD_W-1:0] word_data,
    output logic                   word_valid,
    output logic                   crc_err
);
    localparam int GAP_W   = $clog2(T_SR + 2);
    localparam int STRAY_W = $clog2(PAUSE_STRAYS + 3);
    localparam logic [GAP_W-1:0]   SR_LIM    = GAP_W'(T_SR);
    localparam logic [STRAY_W-1:0] LIM_FAST  = STRAY_W'(1);
    localparam logic [STRAY_W-1:0] LIM_SLOW  = STRAY_W'(2);
    localparam logic [STRAY_W-1:0] LIM_PAUSE = STRAY_W'(PAUSE_STRAYS);

    udma_state_t state_q, state_d;

    logic                   strobe_edge;
    logic [GAP_W-1:0]       edge_gap;
    logic                   hold_done;
    logic                   hold_restart;
    logic [UDMA_WORD_W-1:0] crc_run;
    logic                   crc_reseed;
    logic                   accept;
    logic                   have_word;
    logic [STRAY_W-1:0]     stray_cnt;
    logic [STRAY_W-1:0]     stray_lim;
    logic                   dma_ack_q;
    logic                   ack_fall;
    logic                   end_fast;
    logic                   enter_drain;
    logic                   enter_pause;

    udma_strobe_edge #(.GAP_W(GAP_W)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (host_strobe),
        .edge_o (strobe_edge),
        .gap_o  (edge_gap)
    );

    udma_hold_timer #(.LIMIT(T_RP)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (hold_restart),
        .done    (hold_done)
    );

    udma_crc_acc #(.POLY(CRC_POLY), .SEED(CRC_SEED)) u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .reseed (crc_reseed),
        .step   (accept),
        .word   (host_data),
        .crc    (crc_run)
    );

    assign ack_fall     = dma_ack_q & ~dma_ack;
    assign end_fast     = strobe_edge || (edge_gap < SR_LIM);
    assign enter_drain  = (state_q == ST_XFER) && (state_d == ST_DRAIN);
    assign enter_pause  = (state_q == ST_XFER) && (state_d == ST_PAUSE);
    assign hold_restart = enter_drain;
    assign crc_reseed   = (state_q == ST_REQUEST) && (state_d == ST_XFER);

    // Word acceptance: free in XFER, rationed in PAUSE and DRAIN
    always_comb begin
        accept = 1'b0;
        if (strobe_edge) begin
            unique case (state_q)
                ST_XFER:           accept = 1'b1;
                ST_PAUSE, ST_DRAIN: accept = (stray_cnt < stray_lim);
                default:           accept = 1'b0;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (xfer_req) state_d = ST_REQUEST;
            ST_REQUEST: if (dma_ack)  state_d = ST_XFER;
            ST_XFER: begin
                if (host_stop)
                    state_d = ST_CLOSE;
                else if (end_req && have_word)
                    state_d = ST_DRAIN;
                else if (pause_req)
                    state_d = ST_PAUSE;
            end
            ST_PAUSE:   if (!pause_req) state_d = ST_XFER;
            ST_DRAIN:   if (hold_done)  state_d = ST_CLOSE;
            ST_CLOSE:   if (ack_fall)   state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Handshake outputs decoded from state
    always_comb begin
        dma_req   = 1'b0;
        dev_ready = 1'b0;
        unique case (state_q)
            ST_REQUEST, ST_PAUSE, ST_DRAIN: dma_req = 1'b1;
            ST_XFER: begin
                dma_req   = 1'b1;
                dev_ready = 1'b1;
            end
            default: ;
        endcase
    end

    // Datapath and bookkeeping registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dma_ack_q  <= 1'b0;
            word_valid <= 1'b0;
            word_data  <= '0;
            have_word  <= 1'b0;
            stray_cnt  <= '0;
            stray_lim  <= '0;
            crc_err    <= 1'b0;
        end else begin
            dma_ack_q  <= dma_ack;
            word_valid <= accept;
            if (accept)
                word_data <= host_data;

            if (crc_reseed)
                have_word <= 1'b0;
            else if (accept)
                have_word <= 1'b1;

            if (enter_drain) begin
                stray_cnt <= '0;
                stray_lim <= end_fast ? LIM_FAST : LIM_SLOW;
            end else if (enter_pause) begin
                stray_cnt <= '0;
                stray_lim <= LIM_PAUSE;
            end else if (accept && (state_q != ST_XFER)) begin
                stray_cnt <= stray_cnt + 1'b1;
            end

            if ((state_q == ST_CLOSE) && ack_fall && (host_data != crc_run))
                crc_err <= 1'b1;
            else if (cmd_start)
                crc_err <= 1'b0;
        end
    end

endmodule

// File: rtl/udma_out_rx_chk.sv
`timescale 1ns/1ps
module udma_out_rx_chk #(
    parameter int T_RP = 8
) (
    input logic clk,
    input logic rst_n,
    input logic dma_req,
    input logic dev_ready,
    input logic dma_ack,
    input logic word_valid,
    input logic host_strobe,
    input logic crc_err,
    input logic cmd_start
);
    logic [15:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            low_cnt <= '0;
        else if (dev_ready || !dma_req)
            low_cnt <= '0;
        else if (low_cnt != 16'hFFFF)
            low_cnt <= low_cnt + 1'b1;
    end

    // R2
    ready_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_ready) |-> (dma_ack && dma_req));

    // R5
    ready_inside_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ready |-> dma_req);

    // R5
    rp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dma_req) && !$past(dev_ready)) |-> (low_cnt >= 16'(T_RP)));

    // R8
    closed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_req && !$past(dma_req)) |-> !word_valid);

    // R3
    valid_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> ($past(host_strobe) != $past(host_strobe, 2)));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_err && !cmd_start) |=> crc_err);

endmodule

bind udma_out_rx udma_out_rx_chk #(.T_RP(T_RP)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dma_req     (dma_req),
    .dev_ready   (dev_ready),
    .dma_ack     (dma_ack),
    .word_valid  (word_valid),
    .host_strobe (host_strobe),
    .crc_err     (crc_err),
    .cmd_start   (cmd_start)
);

// File: tb/udma_out_rx_bench.sv
`timescale 1ns/1ps
module udma_out_rx_bench;
    localparam int T_SR = 4;
    localparam int T_RP = 8;
    localparam int PAUSE_STRAYS = 3;
    localparam logic [15:0] POLY = 16'h1021;
    localparam logic [15:0] SEED = 16'h4ABA;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        xfer_req, end_req, pause_req, cmd_start;
    logic        host_strobe, host_stop, dma_ack;
    logic [15:0] host_data;
    logic        dma_req, dev_ready, word_valid, crc_err;
    logic [15:0] word_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done_flag = 0;

    logic [15:0] exp_w [0:63];
    logic [15:0] got_w [0:63];
    int expn, gotn;
    bit exp_err;

    always #2 clk = ~clk;

    udma_out_rx #(.T_SR(T_SR), .T_RP(T_RP), .PAUSE_STRAYS(PAUSE_STRAYS),
                  .CRC_POLY(POLY), .CRC_SEED(SEED)) u_udma_out_rx (
        .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .end_req(end_req),
        .pause_req(pause_req), .cmd_start(cmd_start), .host_strobe(host_strobe),
        .host_stop(host_stop), .dma_ack(dma_ack), .host_data(host_data),
        .dma_req(dma_req), .dev_ready(dev_ready), .word_data(word_data),
        .word_valid(word_valid), .crc_err(crc_err)
    );

    always @(negedge clk) begin
        if (rst_n && word_valid && gotn < 64) begin
            got_w[gotn] = word_data;
            gotn = gotn + 1;
        end
    end

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [15:0] d);
        logic [15:0] r;
        r = c;
        for (int b = 15; b >= 0; b--) begin
            if (r[15] ^ d[b]) r = (r << 1) ^ POLY;
            else              r = r << 1;
        end
        return r;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic strobe_word(input logic [15:0] d, input bit keep);
        host_data   = d;
        host_strobe = ~host_strobe;
        if (keep) begin
            exp_w[expn] = d;
            expn++;
        end
    endtask

    // One full write burst, closed by the device, the host or after an early end request
    task automatic run_burst(input int n, input bit slow, input bit early_end,
                             input int pstrays, input int strays,
                             input bit corrupt, input bit hstop);
        logic [15:0] c;
        int lim;
        int waited;
        expn = 0;
        gotn = 0;
        xfer_req = 1'b1;
        tick(1);
        chk(dma_req == 1'b1, "R2 dma_req after request", dma_req, 1);
        xfer_req = 1'b0;
        chk(dev_ready == 1'b0, "R2 ready before ack", dev_ready, 0);
        dma_ack = 1'b1;
        tick(1);
        chk(dev_ready == 1'b1, "R2 ready after ack", dev_ready, 1);

        if (early_end) begin
            end_req = 1'b1;
            tick(6);
            chk(dev_ready == 1'b1, "R4 end held off with no word", dev_ready, 1);
            strobe_word(16'($urandom), 1'b1);
            tick(1);
            chk(dev_ready == 1'b1, "R4 ready during first capture", dev_ready, 1);
            tick(1);
            chk(dev_ready == 1'b0, "R4 end honoured after first word", dev_ready, 0);
            end_req = 1'b0;
            lim = 1;
        end else begin
            for (int i = 0; i < n; i++) begin
                strobe_word(16'($urandom), 1'b1);
                tick(2);
            end
            if (pstrays > 0) begin
                pause_req = 1'b1;
                tick(1);
                chk(dev_ready == 1'b0 && dma_req == 1'b1, "R7 pause drops ready only",
                    {dev_ready, dma_req}, 1);
                for (int i = 0; i < pstrays; i++) begin
                    strobe_word(16'($urandom), i < PAUSE_STRAYS);
                    tick(2);
                end
                pause_req = 1'b0;
                tick(1);
                chk(dev_ready == 1'b1, "R7 ready back after pause", dev_ready, 1);
            end
            if (hstop) begin
                host_stop = 1'b1;
                tick(1);
                chk(dev_ready == 1'b0 && dma_req == 1'b0, "R11 host stop drops both",
                    {dev_ready, dma_req}, 0);
                lim = 0;
            end else begin
                if (slow) tick(T_SR + 2);
                end_req = 1'b1;
                tick(1);
                chk(dev_ready == 1'b0, "R5 ready drops after end", dev_ready, 0);
                end_req = 1'b0;
                lim = slow ? 2 : 1;
            end
        end

        if (!hstop) begin
            waited = 0;
            for (int i = 0; i < strays; i++) begin
                strobe_word(16'($urandom), i < lim);
                tick(2);
                waited += 2;
            end
            while (dma_req && waited < 100) begin
                tick(1);
                waited++;
            end
            chk(waited == T_RP, "R5 request hold after ready drop", waited, T_RP);
        end

        host_stop = 1'b1;
        if (host_strobe == 1'b0) host_strobe = 1'b1;
        tick(2);
        chk(dma_req == 1'b0, "R5 request stays low while closing", dma_req, 0);
        c = SEED;
        for (int i = 0; i < expn; i++) c = ref_crc(c, exp_w[i]);
        host_data = corrupt ? (c ^ 16'h0100) : c;
        tick(1);
        dma_ack = 1'b0;
        tick(1);
        if (corrupt) exp_err = 1'b1;
        chk(crc_err == exp_err, "R9 crc compare on ack fall", crc_err, exp_err);
        host_stop = 1'b0;
        tick(2);
        chk(gotn == expn, "R6 R8 accepted word count", gotn, expn);
        for (int i = 0; i < expn && i < gotn; i++)
            chk(got_w[i] == exp_w[i], "R3 captured word value", got_w[i], exp_w[i]);
    endtask

    task automatic clear_err();
        cmd_start = 1'b1;
        tick(1);
        cmd_start = 1'b0;
        exp_err   = 1'b0;
        chk(crc_err == 1'b0, "R10 command start clears flag", crc_err, 0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done_flag) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20517));
        rst_n = 1'b0; xfer_req = 0; end_req = 0; pause_req = 0; cmd_start = 0;
        host_strobe = 1'b1; host_stop = 0; dma_ack = 0; host_data = '0;
        expn = 0; gotn = 0; exp_err = 0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk({dma_req, dev_ready, word_valid, crc_err} == 4'b0, "R1 reset outputs",
            {dma_req, dev_ready, word_valid, crc_err}, 0);

        // R6 short allowance, three strays offered
        run_burst(3, 1'b0, 1'b0, 0, 3, 1'b0, 1'b0);
        // R6 long allowance, three strays offered
        run_burst(4, 1'b1, 1'b0, 0, 3, 1'b0, 1'b0);
        // R4 end request waiting for the first word
        run_burst(1, 1'b0, 1'b1, 0, 2, 1'b0, 1'b0);
        // R8 single word leaves strobe low, closing edge must be dropped
        run_burst(1, 1'b1, 1'b0, 0, 0, 1'b0, 1'b0);
        // R7 pause with four strays offered
        run_burst(2, 1'b1, 1'b0, 4, 1, 1'b0, 1'b0);
        // R11 host stop
        run_burst(3, 1'b0, 1'b0, 0, 0, 1'b0, 1'b1);
        // R9 bad CRC, R10 stays set across a good burst
        run_burst(2, 1'b0, 1'b0, 0, 1, 1'b1, 1'b0);
        run_burst(2, 1'b1, 1'b0, 0, 0, 1'b0, 1'b0);
        chk(crc_err == 1'b1, "R10 flag kept over good burst", crc_err, 1);
        clear_err();

        for (int k = 0; k < 24; k++) begin
            bit hs;
            hs = ($urandom % 6) == 0;
            run_burst(1 + int'($urandom % 8), bit'($urandom % 2), 1'b0,
                      hs ? 0 : int'($urandom % 5), int'($urandom % 4),
                      ($urandom % 5) == 0, hs);
            if ((k % 6) == 5) clear_err();
        end

        done_flag = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule